// File: doc/BRIEF.md
# APB Command-Queue Register-Port Bridge

This block lets software on an APB bus reach the small configuration and status register file of an attached converter, without taking part in that file's handshake. Software writes 32-bit command words into a command queue. A sequencer takes each word off the queue and decodes it as a no-operation, a register read or a register write. For a read or a write it runs one transaction on a register port with a 10-bit address and 16-bit data. Results go into a reply queue, and software drains that queue over APB.

Command and reply traffic is pipelined one command deep. Each command pushes exactly one reply entry, and that entry holds the result of the command before it. The result of the newest command therefore stays inside the bridge until another command arrives. Software sends a dummy no-operation to flush it. A read of the reply queue while it is empty ends with an APB slave error.

Top module: `regport_apb_bridge`

## Requirements
- R1: A command word carries write data in bits [15:0], the register address in bits [25:16] and the opcode in bits [29:26]. Bits [31:30] have no effect. For reads and writes, the address field appears on `rp_addr`. For writes, the data field appears on `rp_wdata`.
- R2: Opcode 4'b0001 starts a port transaction with `rp_we` low, and opcode 4'b0010 starts one with `rp_we` high. Opcode 4'b0000 and every opcode from 4'b0011 to 4'b1111 start no port transaction. `rp_we` is high only together with `rp_en`.
- R3: `rp_en` is high for exactly one cycle per transaction. No new transaction starts until `rp_rdy` has been seen for the current one.
- R4: Each command pushes one reply entry, which holds the result of the previous command. A read's result is the `rp_rdata` value returned with `rp_rdy`. The result of a write or a no-operation is 16'h0000. The first command after reset pushes 16'h0000.
- R5: The result of the newest command is not visible in the reply queue until a further command, such as a no-operation, is issued.
- R6: An APB read at offset 0x4 returns the oldest reply in bits [15:0], with bits [31:16] zero, and removes that reply from the queue.
- R7: An APB read at offset 0x4 while the reply queue is empty completes with `pslverr` high and `prdata` zero, and removes nothing.
- R8: An APB read at offset 0x8 returns status with bit 0 = command queue empty, bit 1 = command queue full, bit 2 = reply queue empty, bit 3 = reply queue full and bit 4 = overflow. All other bits read as zero.
- R9: The command queue holds 16 words. An APB write at offset 0x0 while it is full is discarded, never reaches the register port, and sets the overflow bit, which stays set until reset.
- R10: The reply queue holds 16 entries. While it is full, the sequencer takes no command, and queued commands are kept without loss until space frees up.
- R11: `pready` is always high. `pslverr` is high only in the R7 case. APB writes at offsets 0x4 and 0x8 have no effect. Reads at offset 0x0 and at unmapped offsets return zero.
- R12: A synchronous active-low reset empties both queues, clears the overflow bit, clears the held result to 16'h0000 and returns the sequencer to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB direction, 1 = write |
| paddr | input | APB_AW (12) | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| pslverr | output | 1 | APB slave error |
| rp_en | output | 1 | Register-port transaction strobe |
| rp_we | output | 1 | Register-port write select |
| rp_addr | output | 10 | Register-port address |
| rp_wdata | output | 16 | Register-port write data |
| rp_rdata | input | 16 | Register-port read data |
| rp_rdy | input | 1 | Register-port completion strobe |

## Verification
The assertions assume that `rp_rdy` is a single-cycle strobe and that the converter raises it only for a transaction it was given, in the cycle of `rp_en` or later. They also assume that APB transfers follow the setup-then-access order. The bench's converter model follows these rules. It raises `rp_rdy` once per captured `rp_en`, after a delay of zero to three cycles that rotates from one transaction to the next. It can also hold the strobe back indefinitely to create backpressure. The APB tasks always drive a setup cycle and then one access cycle, so the stimulus stays inside these assumptions.

// File: rtl/rpb_pkg.sv
// Package rpb_pkg
// Shared constants and types for the APB register-port bridge.
// Assumes the fixed command word layout: data [15:0], address [25:16], opcode [29:26].
package rpb_pkg;

    localparam int RP_AW   = 10;                    // register-port address width
    localparam int RP_DW   = 16;                    // register-port data width
    localparam int OP_W    = 4;                     // opcode width
    localparam int CMD_W   = OP_W + RP_AW + RP_DW;  // stored command bits (spare bits dropped)
    localparam int APB_DW  = 32;                    // APB data width

    // Byte offsets of the APB-visible locations.
    localparam int OFF_CMD  = 'h0;
    localparam int OFF_REP  = 'h4;
    localparam int OFF_STAT = 'h8;

    // Status bit positions.
    localparam int ST_CMD_EMPTY = 0;
    localparam int ST_CMD_FULL  = 1;
    localparam int ST_REP_EMPTY = 2;
    localparam int ST_REP_FULL  = 3;
    localparam int ST_OVERFLOW  = 4;
    localparam int ST_W         = 5;

    // Opcode values; every other value acts as a no-operation.
    localparam logic [OP_W-1:0] OPC_NOP   = 4'b0000;
    localparam logic [OP_W-1:0] OPC_READ  = 4'b0001;
    localparam logic [OP_W-1:0] OPC_WRITE = 4'b0010;

    // One queued command, stored without the two spare bits.
    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [RP_AW-1:0] addr;
        logic [RP_DW-1:0] data;
    } cmd_t;

    // Sequencer states.
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_state_e;

endpackage

// File: rtl/rpb_fifo.sv
// Module rpb_fifo
// Synchronous single-clock FIFO with a combinational head output.
// Assumes DEPTH is a power of two. A push while full and a pop while empty are ignored.
module rpb_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    logic [WIDTH-1:0] store [DEPTH];
    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;
    logic [CW-1:0]    fill;
    logic             do_push;
    logic             do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign empty   = (fill == '0);
    assign full    = (fill == CW'(DEPTH));
    assign rdata   = store[rd_ptr];

    // Write the incoming word into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wr_ptr] <= wdata;
        end
    end

    // Advance the pointers and track the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

endmodule

// File: rtl/rpb_sequencer.sv
// Module rpb_sequencer
// Takes commands from the command queue, runs register-port transactions and
// pushes the result of the previous command into the reply queue.
// Assumes rp_rdy pulses once per rp_en, in the cycle of rp_en or later.
module rpb_sequencer
    import rpb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_avail,
    input  logic [CMD_W-1:0] cmd_word,
    output logic             cmd_take,
    input  logic             rep_space,
    output logic             rep_put,
    output logic [RP_DW-1:0] rep_word,
    output logic             rp_en,
    output logic             rp_we,
    output logic [RP_AW-1:0] rp_addr,
    output logic [RP_DW-1:0] rp_wdata,
    input  logic [RP_DW-1:0] rp_rdata,
    input  logic             rp_rdy
);
    seq_state_e       state;
    cmd_t             cmd;
    logic             start;
    logic             is_rd;
    logic             is_wr;
    logic             pend_rd;
    logic [RP_DW-1:0] held;

    assign cmd   = cmd_t'(cmd_word);
    assign is_rd = (cmd.op == OPC_READ);
    assign is_wr = (cmd.op == OPC_WRITE);

    // A command starts when idle, one is queued and the reply queue has room.
    assign start    = (state == SEQ_IDLE) && cmd_avail && rep_space;
    assign cmd_take = start;
    assign rep_put  = start;
    assign rep_word = held;

    // Drive the port strobe and track the held result across commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            held     <= '0;
            pend_rd  <= 1'b0;
            rp_en    <= 1'b0;
            rp_we    <= 1'b0;
            rp_addr  <= '0;
            rp_wdata <= '0;
        end else begin
            rp_en <= 1'b0;
            rp_we <= 1'b0;
            if (start) begin
                if (is_rd || is_wr) begin
                    rp_en    <= 1'b1;
                    rp_we    <= is_wr;
                    rp_addr  <= cmd.addr;
                    rp_wdata <= cmd.data;
                    pend_rd  <= is_rd;
                    state    <= SEQ_WAIT;
                end else begin
                    held <= '0;
                end
            end
            if ((state == SEQ_WAIT) && rp_rdy) begin
                held  <= pend_rd ? rp_rdata : '0;
                state <= SEQ_IDLE;
            end
        end
    end

endmodule

// File: rtl/regport_apb_bridge.sv
// Module regport_apb_bridge
// APB slave in front of a command queue, a reply queue and the port sequencer.
// Assumes APB transfers with a setup cycle followed by one access cycle; no wait states.
module regport_apb_bridge
    import rpb_pkg::*;
#(
    parameter int APB_AW    = 12,
    parameter int CMD_DEPTH = 16,
    parameter int REP_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [APB_AW-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              rp_en,
    output logic              rp_we,
    output logic [9:0]        rp_addr,
    output logic [15:0]       rp_wdata,
    input  logic [15:0]       rp_rdata,
    input  logic              rp_rdy
);
    logic             access;
    logic             hit_cmd;
    logic             hit_rep;
    logic             hit_stat;
    logic             cmd_wr;
    logic             rep_rd;
    logic             cmd_push;
    logic             cmd_pop;
    logic             cmd_empty;
    logic             cmd_full;
    logic [CMD_W-1:0] cmd_head;
    logic             rep_push;
    logic             rep_pop;
    logic             rep_empty;
    logic             rep_full;
    logic [RP_DW-1:0] rep_in;
    logic [RP_DW-1:0] rep_head;
    logic             ovf_q;
    logic [ST_W-1:0]  status;
    logic             unused_spare;

    assign unused_spare = ^pwdata[31:30];

    // Decode the APB access phase against the three mapped offsets.
    assign access   = psel && penable;
    assign hit_cmd  = (paddr == APB_AW'(OFF_CMD));
    assign hit_rep  = (paddr == APB_AW'(OFF_REP));
    assign hit_stat = (paddr == APB_AW'(OFF_STAT));
    assign cmd_wr   = access && pwrite && hit_cmd;
    assign rep_rd   = access && !pwrite && hit_rep;
    assign cmd_push = cmd_wr && !cmd_full;
    assign rep_pop  = rep_rd && !rep_empty;
    assign pready   = 1'b1;
    assign pslverr  = rep_rd && rep_empty;

    // Status word assembled bit by bit.
    always_comb begin
        status               = '0;
        status[ST_CMD_EMPTY] = cmd_empty;
        status[ST_CMD_FULL]  = cmd_full;
        status[ST_REP_EMPTY] = rep_empty;
        status[ST_REP_FULL]  = rep_full;
        status[ST_OVERFLOW]  = ovf_q;
    end

    // Select the read data for the addressed location.
    always_comb begin
        prdata = '0;
        if (access && !pwrite) begin
            if (hit_rep && !rep_empty) begin
                prdata = {{(APB_DW-RP_DW){1'b0}}, rep_head};
            end else if (hit_stat) begin
                prdata = {{(APB_DW-ST_W){1'b0}}, status};
            end
        end
    end

    // Sticky flag for command writes dropped on a full queue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (cmd_wr && cmd_full) begin
            ovf_q <= 1'b1;
        end
    end

    rpb_fifo #(
        .WIDTH (CMD_W),
        .DEPTH (CMD_DEPTH)
    ) u_cmd_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (cmd_push),
        .wdata (pwdata[CMD_W-1:0]),
        .pop   (cmd_pop),
        .rdata (cmd_head),
        .empty (cmd_empty),
        .full  (cmd_full)
    );

    rpb_fifo #(
        .WIDTH (RP_DW),
        .DEPTH (REP_DEPTH)
    ) u_rep_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rep_push),
        .wdata (rep_in),
        .pop   (rep_pop),
        .rdata (rep_head),
        .empty (rep_empty),
        .full  (rep_full)
    );

    rpb_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_avail (!cmd_empty),
        .cmd_word  (cmd_head),
        .cmd_take  (cmd_pop),
        .rep_space (!rep_full),
        .rep_put   (rep_push),
        .rep_word  (rep_in),
        .rp_en     (rp_en),
        .rp_we     (rp_we),
        .rp_addr   (rp_addr),
        .rp_wdata  (rp_wdata),
        .rp_rdata  (rp_rdata),
        .rp_rdy    (rp_rdy)
    );

endmodule

// File: rtl/rpb_checker.sv
// Module rpb_checker
// Temporal checks on the bridge's port handshake and APB responses.
// Assumes rp_rdy pulses only for an issued transaction (same cycle as rp_en or later).
module rpb_checker #(
    parameter int APB_AW = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [APB_AW-1:0] paddr,
    input logic [31:0]       prdata,
    input logic              pslverr,
    input logic              rp_en,
    input logic              rp_we,
    input logic              rp_rdy,
    input logic              ovf,
    input logic              cmd_full
);
    logic busy;

    // Track whether a port transaction is outstanding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else begin
            busy <= (busy || rp_en) && !rp_rdy;
        end
    end

    assert_en_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rp_en |=> !rp_en);

    assert_no_start_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rp_en |-> !busy);

    assert_we_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rp_we |-> rp_en);

    assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    assert_drop_flags_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pwrite && (paddr == APB_AW'(0)) && cmd_full) |=> ovf);

    assert_error_on_read_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> (psel && penable && !pwrite));

    assert_reply_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !pwrite && (paddr == APB_AW'(4))) |-> (prdata[31:16] == 16'h0));

endmodule

bind regport_apb_bridge rpb_checker #(
    .APB_AW (APB_AW)
) u_rpb_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .prdata   (prdata),
    .pslverr  (pslverr),
    .rp_en    (rp_en),
    .rp_we    (rp_we),
    .rp_rdy   (rp_rdy),
    .ovf      (ovf_q),
    .cmd_full (cmd_full)
);

// File: tb/test_regport_apb_bridge.sv
`timescale 1ns/1ps
// Bench for regport_apb_bridge: APB tasks, a converter model and a reply model.
module test_regport_apb_bridge;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          psel = 1'b0;
    logic          penable = 1'b0;
    logic          pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [31:0]   pwdata = '0;
    logic [31:0]   prdata;
    logic          pready;
    logic          pslverr;
    logic          rp_en;
    logic          rp_we;
    logic [9:0]    rp_addr;
    logic [15:0]   rp_wdata;
    logic [15:0]   rp_rdata = '0;
    logic          rp_rdy = 1'b0;

    always #4 clk = ~clk;

    regport_apb_bridge #(.APB_AW(AW)) i_regport_apb_bridge (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .rp_en(rp_en), .rp_we(rp_we), .rp_addr(rp_addr),
        .rp_wdata(rp_wdata), .rp_rdata(rp_rdata), .rp_rdy(rp_rdy)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    logic [15:0] dev_mem [1024];
    logic [15:0] shadow  [1024];
    logic [15:0] exp_q [$];
    logic [15:0] held_exp = '0;
    logic        rsp_stall = 1'b0;
    logic        rsp_pend = 1'b0;
    int          rsp_cnt = 0;
    int          txn_cnt = 0;
    logic        last_we = 1'b0;
    logic [9:0]  last_addr = '0;
    logic [15:0] last_wdata = '0;

    initial begin
        for (int i = 0; i < 1024; i++) begin
            dev_mem[i] = 16'(i * 7) + 16'h1000;
            shadow[i]  = 16'(i * 7) + 16'h1000;
        end
    end

    // Converter model: captures each strobe and answers after 0..3 cycles.
    always @(negedge clk) begin
        if (!rst_n) begin
            rsp_pend = 1'b0;
            rp_rdy   = 1'b0;
        end else begin
            rp_rdy = 1'b0;
            if (rp_en) begin
                rsp_pend   = 1'b1;
                rsp_cnt    = txn_cnt % 4;
                txn_cnt    = txn_cnt + 1;
                last_we    = rp_we;
                last_addr  = rp_addr;
                last_wdata = rp_wdata;
                if (rp_we) dev_mem[rp_addr] = rp_wdata;
                else       rp_rdata = dev_mem[rp_addr];
            end
            if (rsp_pend && !rsp_stall) begin
                if (rsp_cnt == 0) begin
                    rp_rdy   = 1'b1;
                    rsp_pend = 1'b0;
                end else begin
                    rsp_cnt = rsp_cnt - 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    task automatic apb(input logic wr, input logic [AW-1:0] a, input logic [31:0] wd,
                       output logic [31:0] rd, output logic er);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = wd;
        @(negedge clk);
        penable = 1'b1;
        #1;
        rd = prdata;
        er = pslverr;
        check(pready === 1'b1, "R11 pready", 32'(pready), 32'h1);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Record the reply the model expects for one accepted command.
    task automatic model_cmd(input logic [3:0] op, input logic [9:0] a, input logic [15:0] d);
        exp_q.push_back(held_exp);
        held_exp = (op == 4'b0001) ? shadow[a] : 16'h0;
        if (op == 4'b0010) shadow[a] = d;
    endtask

    task automatic issue(input logic [3:0] op, input logic [9:0] a, input logic [15:0] d,
                         input logic [1:0] hi);
        logic [31:0] rd;
        logic        er;
        apb(1'b1, AW'(0), {hi, op, a, d}, rd, er);
        model_cmd(op, a, d);
    endtask

    task automatic expect_reply(input string req);
        logic [31:0] rd;
        logic        er;
        logic [15:0] e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 16'hxxxx;
        apb(1'b0, AW'(4), 32'h0, rd, er);
        check(!er && rd === {16'h0, e}, req, rd, {16'h0, e});
    endtask

    task automatic expect_empty_read(input string req);
        logic [31:0] rd;
        logic        er;
        apb(1'b0, AW'(4), 32'h0, rd, er);
        check(er === 1'b1 && rd === 32'h0, req, {er, rd[30:0]}, 32'h8000_0000);
    endtask

    task automatic expect_status(input logic [31:0] e, input string req);
        logic [31:0] rd;
        logic        er;
        apb(1'b0, AW'(8), 32'h0, rd, er);
        check(!er && rd === e, req, rd, e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
    end

    initial begin
        logic [31:0] rd;
        logic        er;
        int          t0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state and error on empty reply read (R12, R8, R7).
        expect_status(32'h05, "R8 R12 reset status");
        expect_empty_read("R7 empty read");
        expect_status(32'h05, "R7 no pop on error");

        // Sweep every opcode; spare bits vary (R1, R2, R4).
        for (int op = 0; op < 16; op++) begin
            logic [9:0]  a;
            logic [15:0] d;
            a  = 10'(op * 61 + 5);
            d  = 16'(op * 16'h1111) ^ 16'h0f0f;
            t0 = txn_cnt;
            issue(4'(op), a, d, 2'(op));
            wait_cyc(12);
            if (op == 1 || op == 2) begin
                check(txn_cnt - t0 == 1, "R2 one transaction", 32'(txn_cnt - t0), 32'h1);
                check(last_we == (op == 2), "R2 write select", 32'(last_we), 32'(op == 2));
                check(last_addr == a, "R1 address field", 32'(last_addr), 32'(a));
                if (op == 2) check(last_wdata == d, "R1 data field", 32'(last_wdata), 32'(d));
            end else begin
                check(txn_cnt == t0, "R2 no transaction", 32'(txn_cnt - t0), 32'h0);
            end
            expect_reply("R4 sweep reply");
        end

        // Write then read back the same register (R4, R6).
        for (int i = 0; i < 6; i++) begin
            logic [9:0] a;
            a = 10'(i * 150 + 3);
            issue(4'b0010, a, 16'hA500 + 16'(i), 2'b00);
            issue(4'b0001, a, 16'h0, 2'b11);
            wait_cyc(20);
            expect_reply("R4 pair first");
            expect_reply("R6 pair second");
        end

        // Newest result is held until a dummy command (R5).
        expect_empty_read("R5 result still held");
        issue(4'b0000, 10'h0, 16'h0, 2'b00);
        wait_cyc(10);
        expect_reply("R5 flushed by no-op");

        // Overflow and reply backpressure (R9, R10).
        rsp_stall = 1'b1;
        issue(4'b0001, 10'd77, 16'h0, 2'b00);
        wait_cyc(6);
        for (int i = 0; i < 16; i++) begin
            issue(4'b0010, 10'(200 + i), 16'h3000 + 16'(i), 2'b00);
        end
        apb(1'b1, AW'(0), {2'b00, 4'b0010, 10'd999, 16'hDEAD}, rd, er);
        expect_status(32'h12, "R9 full and overflow");
        rsp_stall = 1'b0;
        wait_cyc(250);
        expect_status(32'h18, "R10 reply full stalls sequencer");
        for (int i = 0; i < 16; i++) expect_reply("R10 drained reply");
        wait_cyc(20);
        expect_reply("R10 queued command kept");
        expect_status(32'h15, "R9 overflow sticky");
        issue(4'b0001, 10'd999, 16'h0, 2'b00);
        issue(4'b0000, 10'h0, 16'h0, 2'b00);
        wait_cyc(20);
        expect_reply("R9 dropped write");
        expect_reply("R9 dropped write never reached port");

        // Writes to read-only offsets and reads of other offsets (R11).
        apb(1'b1, AW'(4), 32'hFFFF_FFFF, rd, er);
        check(!er, "R11 no error on write", 32'(er), 32'h0);
        apb(1'b1, AW'(8), 32'hFFFF_FFFF, rd, er);
        expect_status(32'h15, "R11 status unchanged");
        apb(1'b0, AW'(0), 32'h0, rd, er);
        check(!er && rd === 32'h0, "R11 read offset 0", rd, 32'h0);
        apb(1'b0, AW'('hC), 32'h0, rd, er);
        check(!er && rd === 32'h0, "R11 read unmapped", rd, 32'h0);
        expect_empty_read("R11 reply queue untouched");

        // Reset in the middle of a stalled transaction (R12).
        rsp_stall = 1'b1;
        issue(4'b0001, 10'd5, 16'h0, 2'b00);
        issue(4'b0001, 10'd6, 16'h0, 2'b00);
        wait_cyc(8);
        @(negedge clk);
        rst_n = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        rsp_stall = 1'b0;
        exp_q.delete();
        held_exp = 16'h0;
        expect_status(32'h05, "R12 reset clears queues and overflow");
        issue(4'b0001, 10'd9, 16'h0, 2'b00);
        issue(4'b0000, 10'h0, 16'h0, 2'b00);
        wait_cyc(20);
        expect_reply("R12 held result cleared");
        expect_reply("R12 read after reset");

        summary();
    end

endmodule